// File: doc/BRIEF.md
# Eight-Team First-Press Buzzer Arbiter

This block runs a quiz contest for eight teams. Each team has one push button, and every button is active low. When the host raises the arm input, the block watches the buttons and takes the first clean press as the winner. A clean press is a sampled cycle in which exactly one button is low. The block then latches that team's number and shows it on a seven-segment output. It also starts an audible square-wave tone and ignores every other button until the host pulls the asynchronous reset low.

Each button passes through a two-flop synchroniser before a two-state controller (waiting, locked) sees it. The latched number drives two things: a combinational digit decoder, and a tone divider whose half-period is a parameter. Every pin is plain control or status. There is no data stream here, so there is no valid/ready handshake and no back-pressure.

Top module: `quiz_buzzer`

## Requirements
- R1: After the active-low asynchronous reset, `team_code` is 0, `tone` is low and `seg` shows the digit 0.
- R2: While waiting and armed, a synchronised button pattern with exactly one low bit, bit k (k = 0..7), locks the block with `team_code` = k+1. The code appears after the third rising clock edge following the pin change: two edges cross the synchroniser and one registers the result.
- R3: A sampled pattern with no low bit, or with two or more low bits, is not accepted. `team_code` stays 0 and the block keeps waiting, so a later single press can still win.
- R4: Once locked, `team_code` holds its value whatever the buttons or arm input do, until the next reset.
- R5: While `arm` is low, no press is accepted and `team_code` stays 0.
- R6: `tone` is low whenever the block is not locked.
- R7: While locked, `tone` is a square wave that changes level every TONE_DIV clock cycles. It is low for the first TONE_DIV cycles after the locking edge, then high for TONE_DIV cycles, and so on.
- R8: `seg` is active high with bit 6..0 = segments g,f,e,d,c,b,a. It shows the decimal glyph of `team_code` for codes 0..9. Segment a is lit except for 1 and 4. b is lit except for 5 and 6. c is lit except for 2. d is lit except for 1, 4 and 7. e is lit only for 0, 2, 6 and 8. f is lit except for 1, 2, 3 and 7. g is lit except for 0, 1 and 7. Codes 10..15 blank all segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Host reset, active low, asynchronous |
| arm | input | 1 | Host arm; presses count only while high |
| btn_n | input | 8 | Team buttons, active low, bit k = team k+1 |
| team_code | output | 4 | Latched winning team, 0 when none |
| seg | output | 7 | Seven-segment lines {g,f,e,d,c,b,a}, active high |
| tone | output | 1 | Audible square wave while locked |

## Verification
The assertions assume `arm` is synchronous to `clk` and that the host never lets `team_code` run outside 0..8. They also assume the only way back to waiting is the reset. The bench respects all three. It changes `arm` and the buttons only at falling edges and holds each pattern for several cycles. It clears the block with reset between patterns. A full sweep of all 256 button patterns, with arm high and with arm low, covers every accept and reject case. A second press is then applied after each lock.

// File: rtl/quiz_buzzer_pkg.sv
package quiz_buzzer_pkg;
  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_LOCK = 1'b1
  } arb_state_t;

  localparam int SEG_W = 7;

  // Glyph for one decimal digit; bit 6..0 = g,f,e,d,c,b,a.
  function automatic logic [SEG_W-1:0] digit_glyph(input logic [3:0] d);
    logic [SEG_W-1:0] g;
    case (d)
      4'd0: g = 7'b0111111;
      4'd1: g = 7'b0000110;
      4'd2: g = 7'b1011011;
      4'd3: g = 7'b1001111;
      4'd4: g = 7'b1100110;
      4'd5: g = 7'b1101101;
      4'd6: g = 7'b1111101;
      4'd7: g = 7'b0000111;
      4'd8: g = 7'b1111111;
      4'd9: g = 7'b1101111;
      default: g = 7'b0000000;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/qb_btn_sync.sv
module qb_btn_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din_n,
  output logic [WIDTH-1:0] dout_n
);
  // Released buttons read as 1, so every stage resets high.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din_n[b]};
    end
    assign dout_n[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/qb_arbiter.sv
module qb_arbiter
  import quiz_buzzer_pkg::*;
#(
  parameter int N_TEAMS = 8,
  parameter int CODE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [N_TEAMS-1:0] btn_n_s,
  output logic [CODE_W-1:0]  code,
  output logic               locked
);
  localparam int CNT_W = $clog2(N_TEAMS + 1);

  arb_state_t        state_q;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  low_cnt;
  logic [CODE_W-1:0] cand;
  logic              single;

  // Count the low buttons and remember which one is low.
  always_comb begin
    low_cnt = '0;
    cand    = '0;
    for (int i = 0; i < N_TEAMS; i++) begin
      if (!btn_n_s[i]) begin
        low_cnt = low_cnt + CNT_W'(1);
        cand    = CODE_W'(i + 1);
      end
    end
    single = (low_cnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      code_q  <= '0;
    end else begin
      case (state_q)
        ST_WAIT: if (arm && single) begin
          state_q <= ST_LOCK;
          code_q  <= cand;
        end
        ST_LOCK: ;
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign code   = code_q;
  assign locked = (state_q == ST_LOCK);
endmodule

// File: rtl/qb_seg_decode.sv
module qb_seg_decode
  import quiz_buzzer_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [SEG_W-1:0]  seg
);
  always_comb begin
    if (code > CODE_W'(9)) seg = '0;
    else                   seg = digit_glyph(4'(code));
  end
endmodule

// File: rtl/qb_tone_gen.sv
module qb_tone_gen #(
  parameter int TONE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tone
);
  localparam int DW = (TONE_DIV > 1) ? $clog2(TONE_DIV) : 1;
  localparam logic [DW-1:0] TERM = DW'(TONE_DIV - 1);

  logic [DW-1:0] div_q;
  logic          tone_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tone_q <= 1'b0;
    end else if (!enable) begin
      div_q  <= '0;
      tone_q <= 1'b0;
    end else if (div_q == TERM) begin
      div_q  <= '0;
      tone_q <= ~tone_q;
    end else begin
      div_q  <= div_q + DW'(1);
    end
  end

  assign tone = tone_q & enable;
endmodule

// File: rtl/quiz_buzzer.sv
module quiz_buzzer
  import quiz_buzzer_pkg::*;
#(
  parameter int N_TEAMS     = 8,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TONE_DIV    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [N_TEAMS-1:0] btn_n,
  output logic [CODE_W-1:0]  team_code,
  output logic [SEG_W-1:0]   seg,
  output logic               tone
);
  logic [N_TEAMS-1:0] btn_s;
  logic               locked;

  qb_btn_sync #(.WIDTH(N_TEAMS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din_n(btn_n), .dout_n(btn_s)
  );

  qb_arbiter #(.N_TEAMS(N_TEAMS), .CODE_W(CODE_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .arm(arm), .btn_n_s(btn_s),
    .code(team_code), .locked(locked)
  );

  qb_seg_decode #(.CODE_W(CODE_W)) u_seg (
    .code(team_code), .seg(seg)
  );

  qb_tone_gen #(.TONE_DIV(TONE_DIV)) u_tone (
    .clk(clk), .rst_n(rst_n), .enable(locked), .tone(tone)
  );
endmodule

// File: rtl/quiz_buzzer_chk.sv
module quiz_buzzer_chk #(
  parameter int N_TEAMS = 8,
  parameter int CODE_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm,
  input logic [N_TEAMS-1:0] btn_s,
  input logic [CODE_W-1:0]  team_code,
  input logic               tone
);
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    team_code <= CODE_W'(N_TEAMS)); // R2

  AST_REJECT_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (team_code == '0 && $countones(~btn_s) != 1) |=> team_code == '0); // R3

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (team_code != '0) |=> $stable(team_code)); // R4

  AST_ARM_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (team_code == '0 && !arm) |=> team_code == '0); // R5

  AST_TONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (team_code == '0) |-> !tone); // R6
endmodule

bind quiz_buzzer quiz_buzzer_chk #(.N_TEAMS(N_TEAMS), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .btn_s(btn_s),
  .team_code(team_code), .tone(tone)
);

// File: tb/quiz_buzzer_test.sv
`timescale 1ns/1ps
module quiz_buzzer_test;
  localparam int N  = 8;
  localparam int TD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0;
  logic [N-1:0] btn_n = '1;
  logic [3:0] team_code;
  logic [6:0] seg;
  logic       tone;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  quiz_buzzer #(.N_TEAMS(N), .CODE_W(4), .SYNC_STAGES(2), .TONE_DIV(TD)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .btn_n(btn_n),
    .team_code(team_code), .seg(seg), .tone(tone)
  );

  function automatic logic [6:0] exp_seg(input int d);
    logic a, b, c, dd, e, f, g;
    if (d > 9) return 7'd0;
    a  = !(d == 1 || d == 4);
    b  = !(d == 5 || d == 6);
    c  = (d != 2);
    dd = !(d == 1 || d == 4 || d == 7);
    e  = (d == 0 || d == 2 || d == 6 || d == 8);
    f  = !(d == 1 || d == 2 || d == 3 || d == 7);
    g  = !(d == 0 || d == 1 || d == 7);
    return {g, f, e, dd, c, b, a};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; arm = 1'b0; btn_n = '1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive at a falling edge, let three rising edges pass, sample at the next falling edge.
  task automatic apply(input logic [N-1:0] pat);
    btn_n = pat;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 code", team_code, 0);
    check("R1 tone", tone, 0);
    check("R1 seg", seg, exp_seg(0));

    for (int p = 0; p < 256; p++) begin
      int lows, idx, exp_code;
      lows = 0; idx = 0;
      for (int b = 0; b < N; b++) if (!p[b]) begin lows++; idx = b + 1; end
      exp_code = (lows == 1) ? idx : 0;

      // Armed: R2 accept single, R3 reject none or many
      do_reset();
      arm = 1'b1;
      apply(p[N-1:0]);
      check(lows == 1 ? "R2 accept" : "R3 reject", team_code, exp_code);
      check("R8 seg", seg, exp_seg(exp_code));
      check("R6 tone", tone, 0);
      if (lows == 1) begin
        // R4: another team presses, and arm drops; code must hold
        arm = 1'b0;
        apply(~(N'(1) << ((idx % N))));
        check("R4 hold", team_code, idx);
        btn_n = '1;
      end else begin
        // R3: block still waiting, a later single press wins
        apply(~N'(4));
        check("R3 still waiting", team_code, 3);
      end

      // Disarmed: R5 nothing accepted
      do_reset();
      apply(p[N-1:0]);
      check("R5 arm low", team_code, 0);
      check("R6 tone idle", tone, 0);
    end

    // R7 tone waveform after a lock
    do_reset();
    arm = 1'b1;
    apply(~N'(8'h10));
    check("R2 team5", team_code, 5);
    check("R7 tone j0", tone, 0);
    for (int j = 1; j <= 4 * TD; j++) begin
      @(negedge clk);
      check("R7 tone", tone, (j / TD) % 2);
    end

    // R1 reset in the middle of a lock clears everything
    rst_n = 1'b0;
    #1;
    check("R1 async code", team_code, 0);
    check("R1 async tone", tone, 0);
    check("R1 async seg", seg, exp_seg(0));
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule